// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block is a small word memory shared by several requesters. Each request is one of four operations: a plain load or store, test-and-set, exchange, or replace-add. The block carries each one out as a single indivisible step, so two agents can build locks, swaps and shared counters on it without any help from software. Each requester has its own valid/ready request channel, carrying an opcode, a store select bit, a word address and an operand. It also has its own response channel, which returns one data word and one flag bit.

A round-robin arbiter picks one requester at a time. From the cycle that accepts a request until the cycle in which that requester takes its response, the block accepts no other request. As a result, no other access can fall between the read and the write-back of an operation. All atomic words are held in the single on-chip array, and no requester keeps a private copy.

A typical use is a shared counter. Several agents issue replace-add with operand 1 to the same word, and each agent receives a different ticket number.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset every memory word reads as zero, and no request-ready or response-valid bit is high.
- R2: Opcode 0 with the store bit low is a load: memory is unchanged and the response carries the word. Opcode 0 with the store bit high is a store: the operand is written and the response carries the previous word.
- R3: Opcode 1 (test-and-set) writes the value 1 into the word. It returns the previous word, and the flag is high only when that previous word was non-zero.
- R4: Opcode 2 (exchange) writes the operand into the word and returns the previous word.
- R5: Opcode 3 (replace-add) writes back the word plus the operand, modulo 2^32, and returns that new sum rather than the old word.
- R6: At most one request-ready bit is high in any cycle. After an acceptance, no further request is accepted until the accepted requester has taken its response.
- R7: Among requests waiting at the same time, the next grant goes to the first requester after the last one served, counting cyclically upward. After reset the search starts at requester 0.
- R8: A response stays valid, with unchanged data, until the owning requester raises its response-ready bit.
- R9: When several requesters issue replace-add of 1 to one word at the same time, each receives a distinct value. The values form a gap-free run above the starting contents, handed out in grant order.
- R10: A response becomes valid at the second rising clock edge after the edge that accepts the request. Only the accepting requester's valid bit is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Request present, one bit per requester |
| req_ready | output | NUM_REQ | Request taken this cycle, one bit per requester |
| req_op | input | 2*NUM_REQ | Opcode per requester (0 load/store, 1 test-and-set, 2 exchange, 3 replace-add) |
| req_wr | input | NUM_REQ | Store select for opcode 0 |
| req_addr | input | ADDR_W*NUM_REQ | Word address per requester |
| req_data | input | DATA_W*NUM_REQ | Operand per requester |
| rsp_valid | output | NUM_REQ | Response available, one bit per requester |
| rsp_ready | input | NUM_REQ | Response taken, one bit per requester |
| rsp_data | output | DATA_W*NUM_REQ | Response word per requester |
| rsp_flag | output | NUM_REQ | Previous word was non-zero |

## Verification
The hardest situation to reach from the ports is true contention: all four requesters raise replace-add on the same counter word in the same cycle, and grant order depends on earlier history. The stimulus first serves requester 1 alone, which fixes the rotation pointer. It then launches four concurrent request tasks, so the expected grant order and the expected ticket for each requester are both known in advance. A separate scenario delays one response-ready for several cycles while another requester waits. This shows that the response is held and that no interleaved access gets in.

// File: rtl/atomic_pkg.sv
package atomic_pkg;

   typedef enum logic [1:0] {
      OP_LDST = 2'b00,
      OP_TAS  = 2'b01,
      OP_XCHG = 2'b10,
      OP_ADD  = 2'b11
   } rmw_op_t;

   typedef enum logic [1:0] {
      PH_IDLE = 2'b00,
      PH_EXEC = 2'b01,
      PH_RESP = 2'b10
   } rmw_phase_t;

endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
   parameter int NUM_REQ     = 4,
   parameter bit ROUND_ROBIN = 1'b1,
   localparam int IDX_W      = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req,
   input  logic               advance,
   output logic [NUM_REQ-1:0] grant,
   output logic [IDX_W-1:0]   grant_idx
);

   if (NUM_REQ < 2) begin : g_bad_count
      $error("rr_arbiter needs at least two requesters");
   end

   if (ROUND_ROBIN) begin : g_rotate
      logic [IDX_W-1:0] ptr_q;

      always_comb begin
         grant     = '0;
         grant_idx = '0;
         for (int k = NUM_REQ - 1; k >= 0; k--) begin
            int c;
            c = int'(ptr_q) + k;
            if (c >= NUM_REQ) c = c - NUM_REQ;
            if (req[c]) begin
               grant     = '0;
               grant[c]  = 1'b1;
               grant_idx = IDX_W'(c);
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ptr_q <= '0;
         end else if (advance) begin
            ptr_q <= (int'(grant_idx) == NUM_REQ - 1) ? '0 : grant_idx + 1'b1;
         end
      end
   end else begin : g_fixed
      always_comb begin
         grant     = '0;
         grant_idx = '0;
         for (int k = NUM_REQ - 1; k >= 0; k--) begin
            if (req[k]) begin
               grant     = '0;
               grant[k]  = 1'b1;
               grant_idx = IDX_W'(k);
            end
         end
      end
   end

endmodule

// File: rtl/word_store.sv
module word_store #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_depth
      $error("word_store depth outside supported range");
   end

   logic [DATA_W-1:0] cell_q [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cell_q[w] <= '0;
         end else if (wr_en && wr_addr == ADDR_W'(w)) begin
            cell_q[w] <= wr_data;
         end
      end
   end

   assign rd_data = cell_q[rd_addr];

endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
   import atomic_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  rmw_op_t           op,
   input  logic              store,
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] operand,
   output logic              wr_en,
   output logic [DATA_W-1:0] new_word,
   output logic [DATA_W-1:0] reply,
   output logic              nz_flag
);

   if (DATA_W < 2) begin : g_bad_width
      $error("rmw_alu data width too small");
   end

   logic [DATA_W-1:0] sum;
   assign sum     = old_word + operand;
   assign nz_flag = |old_word;

   always_comb begin
      wr_en    = 1'b1;
      new_word = old_word;
      reply    = old_word;
      unique case (op)
         OP_LDST: begin
            wr_en    = store;
            new_word = operand;
         end
         OP_TAS:  new_word = DATA_W'(1);
         OP_XCHG: new_word = operand;
         OP_ADD: begin
            new_word = sum;
            reply    = sum;
         end
         default: wr_en = 1'b0;
      endcase
   end

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
   import atomic_pkg::*;
#(
   parameter int NUM_REQ     = 4,
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_REQ-1:0]        req_valid,
   output logic [NUM_REQ-1:0]        req_ready,
   input  logic [2*NUM_REQ-1:0]      req_op,
   input  logic [NUM_REQ-1:0]        req_wr,
   input  logic [ADDR_W*NUM_REQ-1:0] req_addr,
   input  logic [DATA_W*NUM_REQ-1:0] req_data,
   output logic [NUM_REQ-1:0]        rsp_valid,
   input  logic [NUM_REQ-1:0]        rsp_ready,
   output logic [DATA_W*NUM_REQ-1:0] rsp_data,
   output logic [NUM_REQ-1:0]        rsp_flag
);

   localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

   if (NUM_REQ < 2 || NUM_REQ > 16) begin : g_bad_req
      $error("atomic_rmw_unit requester count outside 2..16");
   end

   rmw_phase_t        phase_q;
   logic [NUM_REQ-1:0] grant;
   logic [IDX_W-1:0]  grant_idx;
   logic              accept;

   logic [IDX_W-1:0]  own_q;
   rmw_op_t           op_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] opnd_q;
   logic [DATA_W-1:0] old_q;
   logic [DATA_W-1:0] reply_q;
   logic              flag_q;

   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] rd_word;
   logic              alu_we;
   logic [DATA_W-1:0] alu_new;
   logic [DATA_W-1:0] alu_reply;
   logic              alu_flag;
   logic              mem_we;

   rr_arbiter #(
      .NUM_REQ    (NUM_REQ),
      .ROUND_ROBIN(ROUND_ROBIN)
   ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_valid & {NUM_REQ{phase_q == PH_IDLE}}),
      .advance  (accept),
      .grant    (grant),
      .grant_idx(grant_idx)
   );

   assign req_ready = grant;
   assign accept    = |grant;
   assign sel_addr  = req_addr[grant_idx*ADDR_W +: ADDR_W];

   word_store #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_addr(sel_addr),
      .rd_data(rd_word),
      .wr_en  (mem_we),
      .wr_addr(addr_q),
      .wr_data(alu_new)
   );

   rmw_alu #(
      .DATA_W(DATA_W)
   ) u_alu (
      .op      (op_q),
      .store   (wr_q),
      .old_word(old_q),
      .operand (opnd_q),
      .wr_en   (alu_we),
      .new_word(alu_new),
      .reply   (alu_reply),
      .nz_flag (alu_flag)
   );

   assign mem_we = (phase_q == PH_EXEC) && alu_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         own_q   <= '0;
         op_q    <= OP_LDST;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         opnd_q  <= '0;
         old_q   <= '0;
         reply_q <= '0;
         flag_q  <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  own_q   <= grant_idx;
                  op_q    <= rmw_op_t'(req_op[grant_idx*2 +: 2]);
                  wr_q    <= req_wr[grant_idx];
                  addr_q  <= sel_addr;
                  opnd_q  <= req_data[grant_idx*DATA_W +: DATA_W];
                  old_q   <= rd_word;
                  phase_q <= PH_EXEC;
               end
            end
            PH_EXEC: begin
               reply_q <= alu_reply;
               flag_q  <= alu_flag;
               phase_q <= PH_RESP;
            end
            PH_RESP: begin
               if (rsp_ready[own_q]) phase_q <= PH_IDLE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   for (genvar r = 0; r < NUM_REQ; r++) begin : g_lane
      logic mine;
      assign mine = (phase_q == PH_RESP) && (own_q == IDX_W'(r));
      assign rsp_valid[r]                     = mine;
      assign rsp_flag[r]                      = mine & flag_q;
      assign rsp_data[r*DATA_W +: DATA_W]     = mine ? reply_q : '0;
   end

endmodule

// File: rtl/atomic_rmw_checker.sv
module atomic_rmw_checker #(
   parameter int NUM_REQ = 4,
   parameter int DATA_W  = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_REQ-1:0]        req_valid,
   input logic [NUM_REQ-1:0]        req_ready,
   input logic [NUM_REQ-1:0]        rsp_valid,
   input logic [NUM_REQ-1:0]        rsp_ready,
   input logic [DATA_W*NUM_REQ-1:0] rsp_data
);

   assert_single_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready));

   assert_no_accept_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      |(req_valid & req_ready) |=> req_ready == '0);

   assert_no_accept_while_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      |rsp_valid |-> req_ready == '0);

   assert_rsp_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid & ~rsp_ready) != '0 |=> rsp_valid == $past(rsp_valid) && $stable(rsp_data));

   assert_rsp_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|rsp_valid) |-> rsp_valid == $past(req_valid & req_ready, 2));

   assert_rsp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_valid));

endmodule

bind atomic_rmw_unit atomic_rmw_checker #(
   .NUM_REQ(NUM_REQ),
   .DATA_W (DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .rsp_valid(rsp_valid),
   .rsp_ready(rsp_ready),
   .rsp_data (rsp_data)
);

// File: tb/sim_atomic_rmw_unit.sv
`timescale 1ns/100ps
module sim_atomic_rmw_unit;

   localparam int N  = 4;
   localparam int AW = 4;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [N-1:0]    req_valid, req_ready, req_wr, rsp_valid, rsp_ready, rsp_flag;
   logic [2*N-1:0]  req_op;
   logic [AW*N-1:0] req_addr;
   logic [DW*N-1:0] req_data, rsp_data;

   logic          v_q [N];
   logic [1:0]    op_q [N];
   logic          wr_q [N];
   logic [AW-1:0] ad_q [N];
   logic [DW-1:0] dt_q [N];
   logic          rr_q [N];

   always_comb begin
      for (int i = 0; i < N; i++) begin
         req_valid[i]          = v_q[i];
         req_op[i*2 +: 2]      = op_q[i];
         req_wr[i]             = wr_q[i];
         req_addr[i*AW +: AW]  = ad_q[i];
         req_data[i*DW +: DW]  = dt_q[i];
         rsp_ready[i]          = rr_q[i];
      end
   end

   atomic_rmw_unit #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_wr(req_wr), .req_addr(req_addr), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_data(rsp_data), .rsp_flag(rsp_flag)
   );

   int  total = 0;
   int  bad = 0;
   bit  finished = 0;
   int  acc_log [16];
   int  acc_n = 0;

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_op(input int i, input logic [1:0] op, input logic wr,
                        input logic [AW-1:0] addr, input logic [DW-1:0] data,
                        input int hold, output logic [DW-1:0] d_o, output logic f_o);
      bit got;
      int lat;
      logic [DW-1:0] first;
      @(negedge clk);
      op_q[i] = op; wr_q[i] = wr; ad_q[i] = addr; dt_q[i] = data; v_q[i] = 1'b1;
      forever begin
         #1 got = req_ready[i];
         @(posedge clk);
         if (got) break;
      end
      acc_log[acc_n] = i;
      acc_n++;
      @(negedge clk);
      v_q[i] = 1'b0;
      lat = 1;
      while (!rsp_valid[i]) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == 2, "R10 latency", DW'(lat), 2);
      first = rsp_data[i*DW +: DW];
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         #1;
         chk(rsp_valid[i] && rsp_data[i*DW +: DW] == first, "R8 response held",
             rsp_data[i*DW +: DW], first);
         chk(req_ready == '0, "R6 no accept while pending", DW'(req_ready), 0);
      end
      d_o = rsp_data[i*DW +: DW];
      f_o = rsp_flag[i];
      rr_q[i] = 1'b1;
      @(negedge clk);
      rr_q[i] = 1'b0;
   endtask

   task automatic t_reset;
      logic [DW-1:0] d; logic f;
      chk(req_ready == '0 && rsp_valid == '0, "R1 reset outputs", DW'({req_ready, rsp_valid}), 0);
      for (int a = 0; a < 16; a += 5) begin
         do_op(0, 2'b00, 1'b0, AW'(a), '0, 0, d, f);
         chk(d == 0 && f == 0, "R1 memory cleared", d, 0);
      end
   endtask

   task automatic t_ldst;
      logic [DW-1:0] d; logic f;
      do_op(1, 2'b00, 1'b1, 4'd3, 32'hCAFE_0001, 0, d, f);
      chk(d == 0, "R2 store returns old", d, 0);
      do_op(2, 2'b00, 1'b0, 4'd3, 32'h1111_1111, 0, d, f);
      chk(d == 32'hCAFE_0001 && f, "R2 load data", d, 32'hCAFE_0001);
      do_op(2, 2'b00, 1'b0, 4'd3, '0, 0, d, f);
      chk(d == 32'hCAFE_0001, "R2 load leaves memory", d, 32'hCAFE_0001);
   endtask

   task automatic t_tas;
      logic [DW-1:0] d; logic f;
      do_op(0, 2'b01, 1'b0, 4'd7, 32'h55, 0, d, f);
      chk(d == 0 && !f, "R3 tas on free word", {d[30:0], f}, 0);
      do_op(3, 2'b01, 1'b0, 4'd7, 32'h55, 0, d, f);
      chk(d == 1 && f, "R3 tas on held word", {d[30:0], f}, 3);
      do_op(3, 2'b00, 1'b1, 4'd7, 32'h8000_0000, 0, d, f);
      do_op(1, 2'b01, 1'b0, 4'd7, 0, 0, d, f);
      chk(d == 32'h8000_0000 && f, "R3 tas flag on high bit", d, 32'h8000_0000);
      do_op(1, 2'b00, 1'b0, 4'd7, 0, 0, d, f);
      chk(d == 1, "R3 tas writes one", d, 1);
   endtask

   task automatic t_xchg;
      logic [DW-1:0] d; logic f;
      do_op(2, 2'b10, 1'b0, 4'd9, 32'hA5A5_0000, 0, d, f);
      chk(d == 0, "R4 xchg old value", d, 0);
      do_op(0, 2'b10, 1'b0, 4'd9, 32'h0000_5A5A, 0, d, f);
      chk(d == 32'hA5A5_0000, "R4 xchg second old", d, 32'hA5A5_0000);
      do_op(0, 2'b00, 1'b0, 4'd9, 0, 0, d, f);
      chk(d == 32'h0000_5A5A, "R4 xchg stored", d, 32'h0000_5A5A);
   endtask

   task automatic t_add_wrap;
      logic [DW-1:0] d; logic f;
      do_op(1, 2'b00, 1'b1, 4'd12, 32'hFFFF_FFFE, 0, d, f);
      do_op(1, 2'b11, 1'b0, 4'd12, 32'd3, 0, d, f);
      chk(d == 1, "R5 add returns wrapped sum", d, 1);
      do_op(1, 2'b00, 1'b0, 4'd12, 0, 0, d, f);
      chk(d == 1, "R5 add writes sum", d, 1);
   endtask

   task automatic t_hold;
      logic [DW-1:0] d0, d3; logic f0, f3;
      acc_n = 0;
      fork
         do_op(0, 2'b11, 1'b0, 4'd14, 32'd10, 5, d0, f0);
         begin
            @(negedge clk); @(negedge clk);
            do_op(3, 2'b11, 1'b0, 4'd14, 32'd20, 0, d3, f3);
         end
      join
      chk(d0 == 10, "R8 held response value", d0, 10);
      chk(d3 == 30 && acc_log[1] == 3, "R6 waiter served after release", d3, 30);
   endtask

   task automatic t_contend;
      logic [DW-1:0] d [N];
      logic f [N];
      logic [DW-1:0] tmp; logic ft;
      do_op(0, 2'b00, 1'b1, 4'd5, 32'd100, 0, tmp, ft);
      do_op(1, 2'b00, 1'b0, 4'd5, 0, 0, tmp, ft);
      acc_n = 0;
      fork
         do_op(0, 2'b11, 1'b0, 4'd5, 32'd1, 0, d[0], f[0]);
         do_op(1, 2'b11, 1'b0, 4'd5, 32'd1, 0, d[1], f[1]);
         do_op(2, 2'b11, 1'b0, 4'd5, 32'd1, 0, d[2], f[2]);
         do_op(3, 2'b11, 1'b0, 4'd5, 32'd1, 0, d[3], f[3]);
      join
      for (int k = 0; k < N; k++) begin
         int exp_id;
         exp_id = (2 + k) % N;
         chk(acc_log[k] == exp_id, "R7 rotation order", DW'(acc_log[k]), DW'(exp_id));
         chk(d[exp_id] == DW'(101 + k), "R9 distinct ticket", d[exp_id], DW'(101 + k));
      end
      do_op(2, 2'b00, 1'b0, 4'd5, 0, 0, tmp, ft);
      chk(tmp == 104, "R9 counter final", tmp, 104);
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         v_q[i] = 0; op_q[i] = 0; wr_q[i] = 0; ad_q[i] = 0; dt_q[i] = 0; rr_q[i] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ldst();
      t_tas();
      t_xchg();
      t_add_wrap();
      t_hold();
      t_contend();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule